// File: doc/BRIEF.md
# Sensor Register Write Controller (I2C, 8-bit index, 16-bit value)

This block is the only master on a two-wire I2C bus and programs one 16-bit register in a peripheral device per request. The user logic presents four inputs and a one-cycle start pulse. The first input is a device byte, which already carries the R/W bit. The second is an 8-bit register index, and the third and fourth are the high and low bytes of a 16-bit value. The controller then sends a four-byte write frame and returns either a one-cycle completion pulse or a one-cycle failure pulse.

The bus clock comes from a counter that divides the system clock into quarter periods of `QTR_CYCLES` cycles. Each bit takes four quarters. SDA is open drain. The `sda_low_o` output asks the pad to pull the line down, and SDA is otherwise left to the external pull-up. The controller reads the resolved line level on `sda_in_i` and checks the acknowledge after every byte. If an acknowledge is missing, the controller ends the frame early and reports failure.

Top module: `i2c_reg_writer`

## Requirements
- R1: After reset, and whenever no transfer is running, `scl_o` is 1, `sda_low_o` is 0, and `done_o` and `err_o` are 0.
- R2: A `start_i` sampled high while idle is accepted, and the next cycle begins a sequence of quarters of exactly `QTR_CYCLES` cycles each. The first three quarters form the start condition: first SCL high with SDA released, then SCL high with SDA pulled low, then SCL low with SDA low.
- R3: Every bit slot is four quarters with SCL low, high, high, low. The SDA level for the slot is set in its first quarter and does not change until the slot ends.
- R4: The 32 frame bits go out MSB first in this order: device byte, register index, value bits 15..8, value bits 7..0. A 0 bit drives `sda_low_o`=1 and a 1 bit leaves `sda_low_o`=0.
- R5: A ninth slot follows each byte, and the master keeps SDA released during it. The line is sampled in the last cycle of the slot's second high quarter, and a low level counts as acknowledge.
- R6: After the fourth acknowledge, a stop takes three quarters: SCL low with SDA low, SCL high with SDA low, then SCL high with SDA released. In the cycle after that, `done_o` is 1 for exactly one cycle. An accepted frame with no failure lasts 150 quarters before that pulse.
- R7: If an acknowledge samples high, no further byte is sent. The stop of R6 follows that ninth slot at once, and `err_o` pulses for one cycle in place of `done_o`.
- R8: A `start_i` pulse that arrives while a transfer is running, up to and including the last cycle of the stop, is ignored and leaves the bus waveform unchanged.
- R9: `done_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to start a write frame |
| dev_byte_i | input | 8 | Device address with the R/W bit included |
| reg_addr_i | input | 8 | Register index inside the device |
| wr_data_i | input | 16 | Value to write, high byte sent first |
| sda_in_i | input | 1 | Sensed level of the SDA line |
| scl_o | output | 1 | Bus clock |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| done_o | output | 1 | One-cycle pulse when a frame completes with all acknowledges |
| err_o | output | 1 | One-cycle pulse when a frame ends on a missing acknowledge |

## Verification
Several internal faults show up on the wires before a frame is over. A wrong quarter count shifts the first SCL edge within a few cycles of acceptance. A shifter or bit counter that is off by one puts the wrong level on SDA within one bit slot, or moves the acknowledge slot. A misplaced acknowledge sample changes the point at which the stop begins. The bench predicts the level of every output in every cycle of a frame, covering the complete, early-terminated and interrupted cases. A fault therefore shows up at its first wrong cycle rather than only at the final strobe.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_BITS  = 2'd2,
    PH_STOP  = 2'd3
  } phase_e;

  localparam int FRAME_BYTES = 4;
  localparam int FRAME_W     = 8 * FRAME_BYTES;
endpackage

// File: rtl/i2cw_qtick.sv
module i2cw_qtick #(
  parameter int QTR_CYCLES = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(QTR_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)       cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  // quarter counter never runs past its period (R2)
  p_qcount_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/i2cw_shifter.sv
module i2cw_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         cur_bit,
  output logic         nxt_bit
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign cur_bit = sr[W-1];
  assign nxt_bit = sr[W-2];
endmodule

// File: rtl/i2cw_seq.sv
module i2cw_seq
  import i2cw_pkg::*;
#(
  parameter int NBYTES = FRAME_BYTES
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic tick,
  input  logic cur_bit,
  input  logic nxt_bit,
  input  logic sda_in_i,
  output logic run,
  output logic load,
  output logic shift,
  output logic scl_o,
  output logic sda_low_o,
  output logic done_o,
  output logic err_o
);
  localparam int BYW = $clog2(NBYTES + 1);
  localparam logic [BYW-1:0] LAST_BYTE = BYW'(NBYTES - 1);

  phase_e         phase;
  logic [1:0]     sub;
  logic [3:0]     bitc;
  logic [BYW-1:0] bytec;
  logic           nack;
  logic           ack_slot;

  assign ack_slot = (bitc == 4'd8);
  assign run      = (phase != PH_IDLE);
  assign load     = start_i && (phase == PH_IDLE);
  assign shift    = (phase == PH_BITS) && tick && (sub == 2'd3) && !ack_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      sub       <= 2'd0;
      bitc      <= 4'd0;
      bytec     <= '0;
      nack      <= 1'b0;
      scl_o     <= 1'b1;
      sda_low_o <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start_i) begin
            phase     <= PH_START;
            sub       <= 2'd0;
            bitc      <= 4'd0;
            bytec     <= '0;
            nack      <= 1'b0;
            scl_o     <= 1'b1;
            sda_low_o <= 1'b0;
          end
        end
        PH_START: begin
          if (tick) begin
            case (sub)
              2'd0: begin sub <= 2'd1; sda_low_o <= 1'b1; end
              2'd1: begin sub <= 2'd2; scl_o <= 1'b0; end
              default: begin
                phase     <= PH_BITS;
                sub       <= 2'd0;
                sda_low_o <= ~cur_bit;
              end
            endcase
          end
        end
        PH_BITS: begin
          if (tick) begin
            case (sub)
              2'd0: begin sub <= 2'd1; scl_o <= 1'b1; end
              2'd1: sub <= 2'd2;
              2'd2: begin
                sub   <= 2'd3;
                scl_o <= 1'b0;
                if (ack_slot) nack <= sda_in_i;
              end
              default: begin
                sub <= 2'd0;
                if (ack_slot) begin
                  if (nack || bytec == LAST_BYTE) begin
                    phase     <= PH_STOP;
                    sda_low_o <= 1'b1;
                  end else begin
                    bytec     <= bytec + 1'b1;
                    bitc      <= 4'd0;
                    sda_low_o <= ~cur_bit;
                  end
                end else begin
                  bitc      <= bitc + 1'b1;
                  sda_low_o <= (bitc == 4'd7) ? 1'b0 : ~nxt_bit;
                end
              end
            endcase
          end
        end
        default: begin
          if (tick) begin
            case (sub)
              2'd0: begin sub <= 2'd1; scl_o <= 1'b1; end
              2'd1: begin sub <= 2'd2; sda_low_o <= 1'b0; end
              default: begin
                phase  <= PH_IDLE;
                sub    <= 2'd0;
                done_o <= ~nack;
                err_o  <= nack;
              end
            endcase
          end
        end
      endcase
    end
  end

  p_idle_bus_r1: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> (scl_o && !sda_low_o));

  p_sda_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_BITS && $past(phase) == PH_BITS && scl_o && $past(scl_o))
      |-> $stable(sda_low_o));

  p_ack_release_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_BITS && ack_slot) |-> !sda_low_o);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o));
endmodule

// File: rtl/i2c_reg_writer.sv
module i2c_reg_writer
  import i2cw_pkg::*;
#(
  parameter int QTR_CYCLES = 250
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [7:0]  dev_byte_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [15:0] wr_data_i,
  input  logic        sda_in_i,
  output logic        scl_o,
  output logic        sda_low_o,
  output logic        done_o,
  output logic        err_o
);
  logic run, tick, load, shift, cur_bit, nxt_bit;

  i2cw_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_qtick (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick)
  );

  i2cw_shifter #(.W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_val({dev_byte_i, reg_addr_i, wr_data_i}),
    .shift   (shift),
    .cur_bit (cur_bit),
    .nxt_bit (nxt_bit)
  );

  i2cw_seq #(.NBYTES(FRAME_BYTES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .tick     (tick),
    .cur_bit  (cur_bit),
    .nxt_bit  (nxt_bit),
    .sda_in_i (sda_in_i),
    .run      (run),
    .load     (load),
    .shift    (shift),
    .scl_o    (scl_o),
    .sda_low_o(sda_low_o),
    .done_o   (done_o),
    .err_o    (err_o)
  );
endmodule

// File: tb/test_i2c_reg_writer.sv
module test_i2c_reg_writer;
  localparam int Q = 3;

  typedef struct {
    bit    scl;
    bit    low;
    bit    done;
    bit    err;
    bit    pull;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [7:0]  dev_byte_i = '0;
  logic [7:0]  reg_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        sda_in_i;
  logic        scl_o, sda_low_o, done_o, err_o;
  bit          slave_pull = 1'b0;

  int tests = 0;
  int fails = 0;
  int wd = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  assign sda_in_i = ~(sda_low_o | slave_pull);

  i2c_reg_writer #(.QTR_CYCLES(Q)) i_i2c_reg_writer (
    .clk(clk), .rst(rst), .start_i(start_i), .dev_byte_i(dev_byte_i),
    .reg_addr_i(reg_addr_i), .wr_data_i(wr_data_i), .sda_in_i(sda_in_i),
    .scl_o(scl_o), .sda_low_o(sda_low_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic push_one(bit scl, bit low, bit done, bit err, bit pull, string req);
    exp_t e;
    e.scl = scl; e.low = low; e.done = done; e.err = err; e.pull = pull; e.req = req;
    q.push_back(e);
  endtask

  task automatic push_sym(bit scl, bit low, bit pull, string req);
    for (int i = 0; i < Q; i++) push_one(scl, low, 1'b0, 1'b0, pull, req);
  endtask

  // reference: cycle-by-cycle expected waveform of one frame
  task automatic build(bit [7:0] dv, bit [7:0] rg, bit [15:0] dt, int nack_byte);
    bit [31:0] fr;
    bit [7:0]  by;
    fr = {dv, rg, dt};
    push_one(1, 0, 0, 0, 0, "R1");            // cycle before acceptance edge
    push_sym(1, 0, 0, "R2");
    push_sym(1, 1, 0, "R2");
    push_sym(0, 1, 0, "R2");
    for (int j = 0; j < 4; j++) begin
      by = fr[31 - 8*j -: 8];
      for (int k = 7; k >= 0; k--) begin
        push_sym(0, ~by[k], 0, "R4");
        push_sym(1, ~by[k], 0, "R3");
        push_sym(1, ~by[k], 0, "R3");
        push_sym(0, ~by[k], 0, "R4");
      end
      push_sym(0, 0, j != nack_byte, "R5");
      push_sym(1, 0, j != nack_byte, "R5");
      push_sym(1, 0, j != nack_byte, "R5");
      push_sym(0, 0, j != nack_byte, "R5");
      if (j == nack_byte) break;
    end
    push_sym(0, 1, 0, "R6");
    push_sym(1, 1, 0, "R6");
    push_sym(1, 0, 0, "R6");
    if (nack_byte < 0) push_one(1, 0, 1, 0, 0, "R6");
    else               push_one(1, 0, 0, 1, 0, "R7");
    push_one(1, 0, 0, 0, 0, "R9");
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      exp_t e;
      if (q.size() > 0) e = q.pop_front();
      else begin
        e.scl = 1; e.low = 0; e.done = 0; e.err = 0; e.pull = 0; e.req = "R1";
      end
      slave_pull = e.pull;
      tests++;
      if (scl_o !== e.scl || sda_low_o !== e.low || done_o !== e.done || err_o !== e.err) begin
        fails++;
        $display("FAIL %s t=%0t: scl/low/done/err actual %b%b%b%b expected %b%b%b%b",
                 e.req, $time, scl_o, sda_low_o, done_o, err_o, e.scl, e.low, e.done, e.err);
      end
    end
  end

  // inject > 0: an extra start pulse sampled inject edges after acceptance (R8)
  task automatic run_txn(bit [7:0] dv, bit [7:0] rg, bit [15:0] dt, int nack_byte, int inject);
    @(posedge clk); #2;
    dev_byte_i = dv; reg_addr_i = rg; wr_data_i = dt; start_i = 1'b1;
    build(dv, rg, dt, nack_byte);
    @(posedge clk); #2;
    start_i = 1'b0;
    if (inject > 0) begin
      repeat (inject - 1) @(posedge clk);
      #2;
      dev_byte_i = 8'h00; reg_addr_i = 8'hFF; wr_data_i = 16'h0000; start_i = 1'b1;
      @(posedge clk); #2;
      start_i = 1'b0;
    end
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    repeat (5) @(negedge clk);                    // R1 idle after reset
    run_txn(8'hBA, 8'h04, 16'h0284, -1, 0);       // R4 R6 typical write
    run_txn(8'hBA, 8'h55, 16'hA5F0, -1, 0);       // R3 alternating bits
    run_txn(8'hFF, 8'h00, 16'hFFFF, -1, 0);       // R4 extremes
    run_txn(8'hBA, 8'h01, 16'h1234, 0, 0);        // R7 no device
    run_txn(8'hBA, 8'h20, 16'h0000, 2, 0);        // R7 nack on data high
    run_txn(8'hBA, 8'hA0, 16'h00FF, 3, 0);        // R7 nack on last byte
    run_txn(8'hBA, 8'h06, 16'h0082, -1, 40);      // R8 start mid-transfer
    run_txn(8'hBA, 8'h05, 16'h03FF, -1, 150 * Q); // R8 start on last stop cycle
    run_txn(8'h90, 8'h3C, 16'hC3C3, -1, 0);       // R2 R5 R9 back to normal
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule